// File: doc/BRIEF.md
# Shorted-Load Fault Protection Controller

This block supervises the gate drives of a bank of low-side power switches and protects them against shorted loads. Each channel has an enable command and a drain-over-reference indication from an external comparator. When a channel is enabled its gate output turns on. A blanking window then lets the drain voltage settle. After that, a drain level that stays above the reference for a full deglitch window is treated as a shorted load.

A short sets the channel's bit in the fault register and raises a combined fault flag. The response is chosen at elaboration. In latch mode the gate is held off until the controller cycles the enable. In retry mode the gate is driven with a low-duty-cycle pulse train. Each pulse is blanked and deglitched like a normal turn-on, and the first pulse that shows no short clears the fault and restores continuous drive. A clear input wipes the fault register, for example after power-up.

All times are parameters counted in clock cycles. The comparator inputs pass through a multi-flop synchronizer. The channel enables are assumed to be synchronous to the clock.

Top module: `sld_guard`

## Requirements
- R1: While reset is asserted and after it is released with no enables, every gate output is 0, every fault bit is 0 and the combined flag is 0.
- R2: A channel's gate output turns on in the cycle after its enable is first sampled high. It turns off in the cycle after its enable is sampled low, in both modes.
- R3: After a gate turn-on, no short is declared for BLANK_CYC cycles. With the drain held above reference from turn-on, the gate stays on for exactly BLANK_CYC+DEGL_CYC cycles and the fault appears in the next cycle.
- R4: After blanking, a short is declared only when the synchronized drain input is high for DEGL_CYC consecutive clock edges. Any low sample restarts the count.
- R5: Fault bit i of the fault output belongs to channel i. The combined flag is 1 exactly when any fault bit is 1.
- R6: In latch mode (RETRY_MODE=0) a short turns the gate off and it stays off even when the short is removed. The fault bit is kept while the channel is disabled. The next enable rising edge clears the bit and turns the gate back on.
- R7: In retry mode (RETRY_MODE=1), while the short persists, the gate rises every RETRY_PERIOD cycles. Each pulse lasts BLANK_CYC+DEGL_CYC cycles, and the fault bit stays set throughout.
- R8: In retry mode, once the short is gone, the first pulse of PULSE_W cycles with no qualified short clears the fault bit. The gate then stays on continuously.
- R9: In retry mode, deasserting the enable clears that channel's fault bit in the next cycle.
- R10: The clear input sets all fault bits to 0 in the next cycle, winning over a fault set in the same cycle. It does not turn on any gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | N_CH | Per-channel enable command, synchronous |
| drain_hi | input | N_CH | Per-channel drain-above-reference indication, asynchronous |
| fault_clr | input | 1 | Clear of the whole fault register |
| gate_drv | output | N_CH | Per-channel gate drive |
| fault_bits | output | N_CH | Per-channel fault register, bit i for channel i |
| fault_any | output | 1 | OR of all fault bits |

## Verification
The bench builds two copies with six channels, eight blanking cycles, four deglitch cycles, a 40-cycle retry period and a 20-cycle pulse. One copy is in latch mode and one is in retry mode. These short windows put the exact blanking-to-fault boundary and a deglitch run one sample too short within a few dozen cycles. They also let the bench observe several full retry periods, and recovery from a removed short, in a short run.

// File: rtl/sld_pkg.sv
package sld_pkg;

   typedef enum logic [2:0] {
      CH_OFF   = 3'd0,
      CH_BLANK = 3'd1,
      CH_WATCH = 3'd2,
      CH_TRIP  = 3'd3,
      CH_PULSE = 3'd4,
      CH_HOLD  = 3'd5
   } ch_state_e;

   // Bits needed to hold the values 0 .. limit-1.
   function automatic int cnt_bits(input int limit);
      if (limit <= 2) return 1;
      return $clog2(limit);
   endfunction

endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $fatal(1, "sld_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/sld_chan.sv
module sld_chan
   import sld_pkg::*;
#(
   parameter int BLANK_CYC    = 60,
   parameter int DEGL_CYC     = 10,
   parameter int RETRY_PERIOD = 1000,
   parameter int PULSE_W      = 100,
   parameter int RETRY_MODE   = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic drn_s,
   input  logic clr,
   output logic gate,
   output logic fault
);

   localparam int BW = cnt_bits(BLANK_CYC);
   localparam int DW = cnt_bits(DEGL_CYC);
   localparam int RW = cnt_bits(RETRY_PERIOD);
   localparam logic [BW-1:0] BT_LAST  = BW'(BLANK_CYC - 1);
   localparam logic [DW-1:0] DG_LAST  = DW'(DEGL_CYC - 1);
   localparam logic [RW-1:0] RT_LAST  = RW'(RETRY_PERIOD - 1);
   localparam logic [RW-1:0] RT_PEND  = RW'(PULSE_W - 1);
   localparam logic [RW-1:0] RT_BLANK = RW'(BLANK_CYC);
   localparam ch_state_e     TRIP_TO  = (RETRY_MODE != 0) ? CH_HOLD : CH_TRIP;

   ch_state_e       st;
   logic [BW-1:0]   bt;
   logic [DW-1:0]   dg;
   logic [RW-1:0]   rt;
   logic            check_on;
   logic            deg_done;

   // Short check is live after blanking, on continuous drive or inside a retry pulse.
   assign check_on = (st == CH_WATCH) || ((st == CH_PULSE) && (rt >= RT_BLANK));
   assign deg_done = check_on && drn_s && (dg == DG_LAST);
   assign gate     = (st == CH_BLANK) || (st == CH_WATCH) || (st == CH_PULSE);

   // Deglitch counter: consecutive high samples while the check is live.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      dg <= '0;
      else if (!en || !check_on || !drn_s || deg_done) dg <= '0;
      else                                             dg <= dg + 1'b1;
   end

   // Retry phase counter exists only in the pulsing variant.
   if (RETRY_MODE != 0) begin : g_retry
      localparam logic [RW-1:0] RT_PW = RW'(PULSE_W);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             rt <= '0;
         else if (!en)                           rt <= '0;
         else if (st == CH_WATCH && deg_done)    rt <= RT_PW;
         else if (st == CH_HOLD || st == CH_PULSE)
            rt <= (rt == RT_LAST) ? '0 : rt + 1'b1;
         else                                    rt <= '0;
      end
   end else begin : g_latch
      assign rt = '0;
   end

   // Channel sequence, blanking timer and fault bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= CH_OFF;
         bt    <= '0;
         fault <= 1'b0;
      end else begin
         if (!en) begin
            st <= CH_OFF;
            bt <= '0;
            if (RETRY_MODE != 0) fault <= 1'b0;
         end else begin
            unique case (st)
               CH_OFF: begin
                  st    <= CH_BLANK;
                  bt    <= '0;
                  fault <= 1'b0;
               end
               CH_BLANK: begin
                  if (bt == BT_LAST) st <= CH_WATCH;
                  else               bt <= bt + 1'b1;
               end
               CH_WATCH: begin
                  if (deg_done) begin
                     fault <= 1'b1;
                     st    <= TRIP_TO;
                  end
               end
               CH_TRIP: st <= CH_TRIP;
               CH_PULSE: begin
                  if (deg_done) begin
                     fault <= 1'b1;
                     st    <= CH_HOLD;
                  end else if (rt == RT_PEND) begin
                     fault <= 1'b0;
                     st    <= CH_WATCH;
                  end
               end
               CH_HOLD: begin
                  if (rt == RT_LAST) st <= CH_PULSE;
               end
               default: st <= CH_OFF;
            endcase
         end
         if (clr) fault <= 1'b0;
      end
   end

endmodule

// File: rtl/sld_guard.sv
module sld_guard
   import sld_pkg::*;
#(
   parameter int N_CH         = 6,
   parameter int BLANK_CYC    = 60,
   parameter int DEGL_CYC     = 10,
   parameter int RETRY_PERIOD = 1000,
   parameter int PULSE_W      = 100,
   parameter int RETRY_MODE   = 0,
   parameter int SYNC_STAGES  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] chan_en,
   input  logic [N_CH-1:0] drain_hi,
   input  logic            fault_clr,
   output logic [N_CH-1:0] gate_drv,
   output logic [N_CH-1:0] fault_bits,
   output logic            fault_any
);

   if (N_CH < 1) begin : g_bad_nch
      $fatal(1, "sld_guard: N_CH must be at least 1");
   end
   if (BLANK_CYC < 1 || DEGL_CYC < 1) begin : g_bad_times
      $fatal(1, "sld_guard: BLANK_CYC and DEGL_CYC must be at least 1");
   end
   if (RETRY_MODE != 0 && RETRY_MODE != 1) begin : g_bad_mode
      $fatal(1, "sld_guard: RETRY_MODE must be 0 or 1");
   end
   if (RETRY_MODE != 0 && PULSE_W < BLANK_CYC + DEGL_CYC) begin : g_bad_pulse
      $fatal(1, "sld_guard: PULSE_W must cover blanking plus deglitch");
   end
   if (RETRY_MODE != 0 && RETRY_PERIOD <= PULSE_W) begin : g_bad_period
      $fatal(1, "sld_guard: RETRY_PERIOD must exceed PULSE_W");
   end

   logic [N_CH-1:0] drn_s;

   sld_sync #(
      .WIDTH  (N_CH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (drain_hi),
      .q     (drn_s)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      sld_chan #(
         .BLANK_CYC    (BLANK_CYC),
         .DEGL_CYC     (DEGL_CYC),
         .RETRY_PERIOD (RETRY_PERIOD),
         .PULSE_W      (PULSE_W),
         .RETRY_MODE   (RETRY_MODE)
      ) u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (chan_en[i]),
         .drn_s (drn_s[i]),
         .clr   (fault_clr),
         .gate  (gate_drv[i]),
         .fault (fault_bits[i])
      );
   end

   assign fault_any = |fault_bits;

endmodule

// File: rtl/sld_guard_chk.sv
module sld_guard_chk #(
   parameter int N_CH       = 6,
   parameter int RETRY_MODE = 0
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_CH-1:0] en,
   input logic [N_CH-1:0] gate,
   input logic [N_CH-1:0] fault,
   input logic            clr,
   input logic            flag
);

   // R10: clear empties the register on the next cycle
   a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (fault == '0));

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      // R2: disable turns the gate off next cycle
      a_r2_off_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
         !en[i] |=> !gate[i]);
      // R2: the gate is only driven after an enabled cycle
      a_r2_gate_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
         gate[i] |-> $past(en[i]));
      // R5: a fault is only raised on a channel whose gate was driven
      a_r5_fault_from_drive: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(fault[i]) |-> $past(gate[i]));
      // R5: a raised fault bit shows on the combined flag
      a_r5_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
         fault[i] |-> flag);
      if (RETRY_MODE == 0) begin : g_latch
         // R6: a latched channel never drives its gate
         a_r6_tripped_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
            fault[i] |-> !gate[i]);
      end else begin : g_retry
         // R9: disable clears the fault bit next cycle
         a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |=> !fault[i]);
      end
   end

endmodule

bind sld_guard sld_guard_chk #(
   .N_CH       (N_CH),
   .RETRY_MODE (RETRY_MODE)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .en    (chan_en),
   .gate  (gate_drv),
   .fault (fault_bits),
   .clr   (fault_clr),
   .flag  (fault_any)
);

// File: tb/sld_guard_tb_top.sv
module sld_guard_tb_top;

   localparam int NC  = 6;
   localparam int BL  = 8;
   localparam int DG  = 4;
   localparam int PER = 40;
   localparam int PW  = 20;
   localparam int NV  = 11;

   // Row layout: {en[5:0], drain[5:0], wait[7:0], fault_exp[5:0], gate_exp[5:0]}
   localparam logic [31:0] VEC [NV] = '{
      {6'h00, 6'h00, 8'd5,  6'h00, 6'h00},  // idle
      {6'h3F, 6'h00, 8'd20, 6'h00, 6'h3F},  // all on, no short
      {6'h3F, 6'h01, 8'd20, 6'h01, 6'h3E},  // ch0 short trips
      {6'h3F, 6'h00, 8'd20, 6'h01, 6'h3E},  // short gone, still latched
      {6'h3E, 6'h00, 8'd5,  6'h01, 6'h3E},  // ch0 disabled, bit kept
      {6'h3F, 6'h00, 8'd20, 6'h00, 6'h3F},  // re-enable clears
      {6'h3F, 6'h24, 8'd20, 6'h24, 6'h1B},  // ch2 and ch5 trip
      {6'h00, 6'h00, 8'd5,  6'h24, 6'h00},  // all off, bits kept
      {6'h3F, 6'h3F, 8'd5,  6'h00, 6'h3F},  // turn-on into short, blanked
      {6'h3F, 6'h3F, 8'd15, 6'h3F, 6'h00},  // all trip after window
      {6'h00, 6'h00, 8'd5,  6'h3F, 6'h00}   // disabled, bits kept
   };

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic [NC-1:0] en_l, drn_l, en_r, drn_r;
   logic          clr_l, clr_r;
   logic [NC-1:0] gate_l, fault_l, gate_r, fault_r;
   logic          flag_l, flag_r;

   int  n_chk = 0;
   int  n_fail = 0;
   int  cyc = 0;
   bit  done = 1'b0;

   always @(posedge clk) cyc++;

   sld_guard #(
      .N_CH(NC), .BLANK_CYC(BL), .DEGL_CYC(DG),
      .RETRY_PERIOD(PER), .PULSE_W(PW), .RETRY_MODE(0), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .chan_en(en_l), .drain_hi(drn_l),
      .fault_clr(clr_l), .gate_drv(gate_l), .fault_bits(fault_l), .fault_any(flag_l)
   );

   sld_guard #(
      .N_CH(NC), .BLANK_CYC(BL), .DEGL_CYC(DG),
      .RETRY_PERIOD(PER), .PULSE_W(PW), .RETRY_MODE(1), .SYNC_STAGES(2)
   ) dut_retry_i (
      .clk(clk), .rst_n(rst_n), .chan_en(en_r), .drain_hi(drn_r),
      .fault_clr(clr_r), .gate_drv(gate_r), .fault_bits(fault_r), .fault_any(flag_r)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_rise(output int t);
      logic p;
      t = -1;
      for (int k = 0; k < 300; k++) begin
         p = gate_r[0];
         step(1);
         if (!p && gate_r[0]) begin
            t = cyc;
            break;
         end
      end
   endtask

   initial begin
      int t1, t2, w;
      rst_n = 1'b0;
      en_l = '0; drn_l = '0; clr_l = 1'b0;
      en_r = '0; drn_r = '0; clr_r = 1'b0;
      step(3);
      chk("R1 reset gate latch", 32'(gate_l), 0);
      chk("R1 reset fault latch", 32'(fault_l), 0);
      chk("R1 reset flag latch", 32'(flag_l), 0);
      chk("R1 reset gate retry", 32'(gate_r), 0);
      rst_n = 1'b1;
      step(2);
      chk("R1 idle after reset fault", 32'(fault_r), 0);

      // Table walk on the latch-mode copy (R2 R5 R6)
      for (int v = 0; v < NV; v++) begin
         en_l  = VEC[v][31:26];
         drn_l = VEC[v][25:20];
         step(int'(VEC[v][19:12]));
         chk($sformatf("R6 row %0d fault", v), 32'(fault_l), 32'(VEC[v][11:6]));
         chk($sformatf("R2 row %0d gate", v), 32'(gate_l), 32'(VEC[v][5:0]));
         chk($sformatf("R5 row %0d flag", v), 32'(flag_l), 32'(VEC[v][11:6] != 6'h00));
      end

      // R10: clear wipes bits, gates stay off
      clr_l = 1'b1;
      step(1);
      clr_l = 1'b0;
      chk("R10 clear fault", 32'(fault_l), 0);
      chk("R10 clear flag", 32'(flag_l), 0);
      step(3);
      chk("R10 clear leaves gate off", 32'(gate_l), 0);

      // R3: exact blanking boundary with a short present from turn-on
      drn_l = 6'h3F;
      step(3);
      en_l = 6'h3F;
      step(1);
      chk("R2 gate on next cycle", 32'(gate_l), 32'h3F);
      step(11);
      chk("R3 gate held through window", 32'(gate_l), 32'h3F);
      chk("R3 no fault inside window", 32'(fault_l), 0);
      step(1);
      chk("R3 fault right after window", 32'(fault_l), 32'h3F);
      chk("R3 gate off after window", 32'(gate_l), 0);

      // R4: runs one sample short never trip, a full run does
      en_l = '0; drn_l = '0;
      step(2);
      en_l = 6'h3F;
      step(20);
      for (int r = 0; r < 8; r++) begin
         drn_l = 6'h02; step(DG - 1);
         drn_l = 6'h00; step(2);
      end
      step(4);
      chk("R4 short runs ignored fault", 32'(fault_l), 0);
      chk("R4 short runs ignored gate", 32'(gate_l), 32'h3F);
      drn_l = 6'h02; step(DG);
      drn_l = 6'h00; step(6);
      chk("R4 full run trips ch1", 32'(fault_l), 32'h02);
      chk("R5 only ch1 gate off", 32'(gate_l), 32'h3D);
      chk("R5 flag with one bit", 32'(flag_l), 1);
      en_l = 6'h3D;
      step(1);
      en_l = 6'h00;
      step(1);
      chk("R2 disable turns gates off", 32'(gate_l), 0);

      // Retry-mode copy
      en_r = 6'h01;
      step(20);
      chk("R2 retry gate on", 32'(gate_r), 32'h01);
      drn_r = 6'h01;
      step(15);
      chk("R5 retry fault bit0", 32'(fault_r), 32'h01);
      wait_rise(t1);
      w = 0;
      while (gate_r[0] && w < 100) begin
         step(1);
         w++;
      end
      chk("R7 pulse width", 32'(w), 32'(BL + DG));
      wait_rise(t2);
      chk("R7 pulse period", 32'(t2 - t1), 32'(PER));
      chk("R7 fault kept while pulsing", 32'(fault_r), 32'h01);
      w = 0;
      for (int k = 0; k < 2 * PER; k++) begin
         if (gate_r[0]) w++;
         step(1);
      end
      chk("R7 low duty over two periods", 32'(w), 32'(2 * (BL + DG)));

      drn_r = 6'h00;
      step(2 * PER + 5);
      chk("R8 fault self-clears", 32'(fault_r), 0);
      chk("R8 flag self-clears", 32'(flag_r), 0);
      chk("R8 gate continuous", 32'(gate_r), 32'h01);
      w = 0;
      for (int k = 0; k < PER; k++) begin
         if (gate_r[0]) w++;
         step(1);
      end
      chk("R8 gate stays on a full period", 32'(w), 32'(PER));

      drn_r = 6'h01;
      step(15);
      chk("R9 fault before disable", 32'(fault_r), 32'h01);
      en_r = 6'h00;
      step(1);
      chk("R9 disable clears fault", 32'(fault_r), 0);
      chk("R9 disable gate off", 32'(gate_r), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule